// File: doc/BRIEF.md
# Inquire Snoop Response Unit

This unit answers an external inquire cycle aimed at a processor with split instruction and data caches. A snoop carries a line address and an invalidate qualifier. The unit compares that line against four structures: the instruction cache, the prefetch cache, the data cache and the writeback buffers. It then changes the state of every entry that matched. The store buffer is never part of the lookup.

Line states are MESI-style, encoded as 2'b00 invalid, 2'b01 shared, 2'b10 exclusive and 2'b11 modified. An entry counts as a hit only when its stored line matches and its state is not invalid. Instruction-side entries, meaning the instruction cache and the prefetch cache, are invalidated or left untouched, and are never downgraded. Data-side entries either end shared or are invalidated. When a modified line is hit, the unit raises a hit-modified flag and a writeback request. It holds the state change back until the writeback is acknowledged.

The tag and state arrays are a small behavioural model. They are loaded through a fill port and read back through a combinational query port. The query port returns the state and the full line address. The caches are direct mapped and indexed by the low line-address bits. The buffers are fully associative and addressed by slot number.

Top module: `inquire_snoop_unit`

## Requirements
- R1: After reset every entry of every structure reads invalid, snp_ready is high, and snp_hit, snp_hitm and wb_req are low.
- R2: A snoop is taken at a clock edge where snp_valid and snp_ready are both high. In the following cycle snp_ready is low and snp_hit and snp_hitm give the lookup result.
- R3: snp_hit is high when the line matches a non-invalid entry in any of the four structures. A line with the same cache index but a different tag is a miss, and so is a matching entry that is invalid.
- R4: An instruction-cache or prefetch-cache hit with snp_inv low leaves the entry's state unchanged.
- R5: An instruction-cache or prefetch-cache hit with snp_inv high makes the entry invalid.
- R6: A data-cache hit on a shared or exclusive line with snp_inv low leaves the line shared, without a writeback. The state is written at the second edge, and snp_ready is high again in the cycle after that edge.
- R7: A data-cache hit on a modified line with snp_inv low holds snp_hitm and wb_req high until the edge where wb_ack is sampled high. The line reads modified until that edge, and reads shared afterwards.
- R8: A data-cache hit with snp_inv high makes the line invalid. If the line is modified, this happens only at the edge where wb_ack is taken.
- R9: A writeback-buffer hit raises snp_hitm and wb_req whatever snp_inv is, and the buffer entry is freed (reads invalid) at the acknowledge edge.
- R10: While wb_req is high, wb_line equals the snooped line address and does not change.
- R11: A fill presented while a snoop is in flight, or in the cycle the snoop is taken, is ignored.
- R12: A snoop that misses changes no state and raises neither snp_hitm nor wb_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snp_valid | input | 1 | Snoop request present |
| snp_ready | output | 1 | Unit idle, so a snoop can be taken |
| snp_line | input | AW-OFFW | Snooped line address |
| snp_inv | input | 1 | Invalidate qualifier of the snoop |
| snp_hit | output | 1 | Lookup found a valid match |
| snp_hitm | output | 1 | Lookup found a modified match |
| wb_req | output | 1 | Writeback requested for the snooped line |
| wb_ack | input | 1 | Writeback completed |
| wb_line | output | AW-OFFW | Line address of the requested writeback |
| fill_en | input | 1 | Install an entry |
| fill_sel | input | 2 | Target: 0 instruction cache, 1 prefetch, 2 data cache, 3 writeback buffer |
| fill_slot | input | log2(SETS) | Buffer slot; unused for caches |
| fill_line | input | AW-OFFW | Line address to install |
| fill_state | input | 2 | State to install (any non-invalid value marks a buffer slot used) |
| q_sel | input | 2 | Structure to read, same coding as fill_sel |
| q_idx | input | log2(SETS) | Cache set or buffer slot to read |
| q_state | output | 2 | State of the entry read (a used buffer slot reads modified) |
| q_line | output | AW-OFFW | Line address held by the entry read |

## Verification
The bench builds the unit with AW=16, OFFW=4, SETS=4, PF_N=2 and WB_N=2. With only four sets, lines that share an index but differ in tag are easy to place, so alias misses can be checked next to true hits. Two slots per buffer let the associative match be tried with one slot used and one empty. The narrow line field keeps the writeback address comparisons short, and the acknowledge is held back for several cycles to expose any early state change.

// File: rtl/inquire_snoop_unit.sv
module inquire_snoop_unit #(
  parameter int AW   = 32,
  parameter int OFFW = 5,
  parameter int SETS = 16,
  parameter int PF_N = 4,
  parameter int WB_N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      snp_valid,
  output logic                      snp_ready,
  input  logic [AW-OFFW-1:0]        snp_line,
  input  logic                      snp_inv,
  output logic                      snp_hit,
  output logic                      snp_hitm,
  output logic                      wb_req,
  input  logic                      wb_ack,
  output logic [AW-OFFW-1:0]        wb_line,
  input  logic                      fill_en,
  input  logic [1:0]                fill_sel,
  input  logic [$clog2(SETS)-1:0]   fill_slot,
  input  logic [AW-OFFW-1:0]        fill_line,
  input  logic [1:0]                fill_state,
  input  logic [1:0]                q_sel,
  input  logic [$clog2(SETS)-1:0]   q_idx,
  output logic [1:0]                q_state,
  output logic [AW-OFFW-1:0]        q_line
);
  localparam int LAW  = AW - OFFW;
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = LAW - IDXW;

  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] ST_S = 2'b01;
  localparam logic [1:0] ST_M = 2'b11;

  logic [TAGW-1:0] ic_tag [SETS];
  logic [1:0]      ic_st  [SETS];
  logic [TAGW-1:0] dc_tag [SETS];
  logic [1:0]      dc_st  [SETS];
  logic [LAW-1:0]  pf_ln  [PF_N];
  logic [1:0]      pf_st  [PF_N];
  logic [LAW-1:0]  wb_ln  [WB_N];
  logic            wb_v   [WB_N];

  logic            stg_v, stg_inv, stg_ic, stg_dc, stg_dcm;
  logic [LAW-1:0]  stg_line;
  logic [PF_N-1:0] stg_pf, pf_m;
  logic [WB_N-1:0] stg_wb, wb_m;

  wire [IDXW-1:0] s_idx = snp_line[IDXW-1:0];
  wire [TAGW-1:0] s_tag = snp_line[LAW-1:IDXW];
  wire [IDXW-1:0] c_idx = stg_line[IDXW-1:0];

  wire ic_m  = (ic_st[s_idx] != ST_I) && (ic_tag[s_idx] == s_tag);
  wire dc_m  = (dc_st[s_idx] != ST_I) && (dc_tag[s_idx] == s_tag);
  wire dc_mm = dc_m && (dc_st[s_idx] == ST_M);

  for (genvar i = 0; i < PF_N; i++) begin : g_pf
    assign pf_m[i] = (pf_st[i] != ST_I) && (pf_ln[i] == snp_line);
  end
  for (genvar i = 0; i < WB_N; i++) begin : g_wb
    assign wb_m[i] = wb_v[i] && (wb_ln[i] == snp_line);
  end

  wire stg_mod = stg_dcm || (|stg_wb);
  wire accept  = snp_valid && !stg_v;
  wire commit  = stg_v && (!stg_mod || wb_ack);
  wire fill_ok = fill_en && !stg_v && !snp_valid;

  assign snp_ready = !stg_v;
  assign snp_hit   = stg_v && (stg_ic || stg_dc || (|stg_pf) || (|stg_wb));
  assign snp_hitm  = stg_v && stg_mod;
  assign wb_req    = stg_v && stg_mod;
  assign wb_line   = stg_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= 1'b0; stg_inv <= 1'b0; stg_line <= '0;
      stg_ic <= 1'b0; stg_dc <= 1'b0; stg_dcm <= 1'b0;
      stg_pf <= '0; stg_wb <= '0;
    end else if (accept) begin
      stg_v <= 1'b1; stg_inv <= snp_inv; stg_line <= snp_line;
      stg_ic <= ic_m; stg_dc <= dc_m; stg_dcm <= dc_mm;
      stg_pf <= pf_m; stg_wb <= wb_m;
    end else if (commit) begin
      stg_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        ic_tag[i] <= '0; ic_st[i] <= ST_I;
        dc_tag[i] <= '0; dc_st[i] <= ST_I;
      end
      for (int i = 0; i < PF_N; i++) begin pf_ln[i] <= '0; pf_st[i] <= ST_I; end
      for (int i = 0; i < WB_N; i++) begin wb_ln[i] <= '0; wb_v[i] <= 1'b0; end
    end else if (fill_ok) begin
      case (fill_sel)
        2'd0: begin
          ic_tag[fill_line[IDXW-1:0]] <= fill_line[LAW-1:IDXW];
          ic_st[fill_line[IDXW-1:0]]  <= fill_state;
        end
        2'd1: for (int i = 0; i < PF_N; i++)
                if (fill_slot == IDXW'(i)) begin pf_ln[i] <= fill_line; pf_st[i] <= fill_state; end
        2'd2: begin
          dc_tag[fill_line[IDXW-1:0]] <= fill_line[LAW-1:IDXW];
          dc_st[fill_line[IDXW-1:0]]  <= fill_state;
        end
        default: for (int i = 0; i < WB_N; i++)
                   if (fill_slot == IDXW'(i)) begin wb_ln[i] <= fill_line; wb_v[i] <= (fill_state != ST_I); end
      endcase
    end else if (commit) begin
      if (stg_ic && stg_inv) ic_st[c_idx] <= ST_I;
      if (stg_dc) dc_st[c_idx] <= stg_inv ? ST_I : ST_S;
      for (int i = 0; i < PF_N; i++) if (stg_pf[i] && stg_inv) pf_st[i] <= ST_I;
      for (int i = 0; i < WB_N; i++) if (stg_wb[i]) wb_v[i] <= 1'b0;
    end
  end

  always_comb begin
    q_state = ST_I;
    q_line  = '0;
    case (q_sel)
      2'd0: begin q_state = ic_st[q_idx]; q_line = {ic_tag[q_idx], q_idx}; end
      2'd1: for (int i = 0; i < PF_N; i++)
              if (q_idx == IDXW'(i)) begin q_state = pf_st[i]; q_line = pf_ln[i]; end
      2'd2: begin q_state = dc_st[q_idx]; q_line = {dc_tag[q_idx], q_idx}; end
      default: for (int i = 0; i < WB_N; i++)
                 if (q_idx == IDXW'(i)) begin q_state = wb_v[i] ? ST_M : ST_I; q_line = wb_ln[i]; end
    endcase
  end
endmodule

module inquire_snoop_unit_chk #(
  parameter int LAW = 27
) (
  input logic           clk,
  input logic           rst_n,
  input logic           snp_valid,
  input logic           snp_ready,
  input logic           snp_hit,
  input logic           snp_hitm,
  input logic           wb_req,
  input logic           wb_ack,
  input logic [LAW-1:0] wb_line
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    snp_ready |-> (!wb_req && !snp_hitm && !snp_hit));
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready) |=> !snp_ready);
  a_r6_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_ready && !snp_hitm) |=> snp_ready);
  a_r7_hitm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hitm && !wb_ack) |=> (snp_hitm && wb_req));
  a_r10_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> $stable(wb_line));
  a_r12_no_hitm_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_hit |-> !snp_hitm);
endmodule

bind inquire_snoop_unit inquire_snoop_unit_chk #(.LAW(AW - OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ready(snp_ready),
  .snp_hit(snp_hit), .snp_hitm(snp_hitm), .wb_req(wb_req), .wb_ack(wb_ack),
  .wb_line(wb_line)
);

// File: tb/inquire_snoop_unit_tb.sv
module inquire_snoop_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, OFFW = 4, SETS = 4, PF_N = 2, WB_N = 2;
  localparam int LAW = AW - OFFW;
  localparam int IDXW = $clog2(SETS);

  logic clk = 0, rst_n = 0;
  logic snp_valid = 0, snp_inv = 0, wb_ack = 0, fill_en = 0;
  logic [LAW-1:0] snp_line = '0, fill_line = '0;
  logic [1:0] fill_sel = 0, fill_state = 0, q_sel = 0;
  logic [IDXW-1:0] fill_slot = 0, q_idx = 0;
  logic snp_ready, snp_hit, snp_hitm, wb_req;
  logic [LAW-1:0] wb_line, q_line;
  logic [1:0] q_state;

  int compared = 0, mismatched = 0;
  logic [1:0] exp_q[$];
  logic acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inquire_snoop_unit #(.AW(AW), .OFFW(OFFW), .SETS(SETS), .PF_N(PF_N), .WB_N(WB_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ready(snp_ready),
    .snp_line(snp_line), .snp_inv(snp_inv), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
    .wb_req(wb_req), .wb_ack(wb_ack), .wb_line(wb_line), .fill_en(fill_en),
    .fill_sel(fill_sel), .fill_slot(fill_slot), .fill_line(fill_line),
    .fill_state(fill_state), .q_sel(q_sel), .q_idx(q_idx), .q_state(q_state),
    .q_line(q_line));

  task automatic chk(string rq, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  // monitor: pops the expected lookup result one cycle after a snoop is taken
  always @(posedge clk) acc <= rst_n && snp_valid && snp_ready;
  always @(negedge clk) if (acc) begin
    if (exp_q.size() == 0) chk("R2", "unexpected snoop result", 1, 0);
    else begin
      logic [1:0] e;
      e = exp_q.pop_front();
      chk("R3", "snp_hit", snp_hit, e[1]);
      chk("R12", "snp_hitm", snp_hitm, e[0]);
    end
  end

  task automatic fill(logic [1:0] sel, logic [IDXW-1:0] slot, logic [LAW-1:0] ln, logic [1:0] st);
    @(negedge clk);
    fill_en = 1; fill_sel = sel; fill_slot = slot; fill_line = ln; fill_state = st;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic qchk(string rq, logic [1:0] sel, logic [IDXW-1:0] idx, logic [1:0] st);
    q_sel = sel; q_idx = idx; #1;
    chk(rq, "entry state", q_state, st);
  endtask

  task automatic snoop(string rq, logic [LAW-1:0] ln, logic inv, logic ehit, logic ehitm,
                       int dly, logic [1:0] qs, logic [IDXW-1:0] qi,
                       logic [1:0] held, logic [1:0] fin);
    @(negedge clk);
    snp_valid = 1; snp_line = ln; snp_inv = inv; q_sel = qs; q_idx = qi;
    exp_q.push_back({ehit, ehitm});
    @(negedge clk);
    snp_valid = 0;
    chk("R2", "snp_ready while busy", snp_ready, 0);
    if (ehitm) begin
      for (int k = 0; k <= dly; k++) begin
        #1;
        chk("R7", "hitm held", snp_hitm, 1);
        chk("R10", "wb_line", wb_line, ln);
        chk(rq, "state held before ack", q_state, held);
        if (k < dly) @(negedge clk);
      end
      wb_ack = 1;
      @(negedge clk);
      wb_ack = 0;
    end else begin
      chk("R12", "wb_req", wb_req, 0);
      @(negedge clk);
    end
    #1;
    chk(rq, "ready after commit", snp_ready, 1);
    chk(rq, "hitm after commit", snp_hitm, 0);
    chk(rq, "state after commit", q_state, fin);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "snp_ready", snp_ready, 1);
    chk("R1", "wb_req", wb_req, 0);
    chk("R1", "snp_hitm", snp_hitm, 0);
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 2; i++) qchk("R1", 2'(s), IDXW'(i), 2'd0);

    fill(0, 0, 12'h011, 2'd1);
    fill(1, 0, 12'h022, 2'd1);
    fill(2, 0, 12'h033, 2'd2);
    fill(2, 0, 12'h040, 2'd3);
    fill(3, 1, 12'h055, 2'd3);
    fill(2, 0, 12'h062, 2'd1);

    snoop("R4", 12'h011, 0, 1, 0, 0, 0, 1, 2'd1, 2'd1);
    snoop("R3", 12'h111, 1, 0, 0, 0, 0, 1, 2'd1, 2'd1);
    snoop("R5", 12'h011, 1, 1, 0, 0, 0, 1, 2'd1, 2'd0);
    snoop("R3", 12'h011, 0, 0, 0, 0, 0, 1, 2'd0, 2'd0);
    snoop("R4", 12'h022, 0, 1, 0, 0, 1, 0, 2'd1, 2'd1);
    snoop("R5", 12'h022, 1, 1, 0, 0, 1, 0, 2'd1, 2'd0);
    snoop("R6", 12'h033, 0, 1, 0, 0, 2, 3, 2'd2, 2'd1);
    snoop("R8", 12'h062, 1, 1, 0, 0, 2, 2, 2'd1, 2'd0);
    snoop("R7", 12'h040, 0, 1, 1, 3, 2, 0, 2'd3, 2'd1);
    fill(2, 0, 12'h040, 2'd3);
    snoop("R8", 12'h040, 1, 1, 1, 0, 2, 0, 2'd3, 2'd0);
    snoop("R9", 12'h055, 0, 1, 1, 2, 3, 1, 2'd3, 2'd0);

    // R11: fill offered with the snoop and during its lookup
    @(negedge clk);
    snp_valid = 1; snp_line = 12'h033; snp_inv = 0;
    fill_en = 1; fill_sel = 2; fill_line = 12'h073; fill_state = 2'd3;
    exp_q.push_back(2'b10);
    @(negedge clk);
    snp_valid = 0;
    @(negedge clk);
    fill_en = 0;
    qchk("R11", 2, 3, 2'd1);
    chk("R11", "line kept", q_line, 12'h033);

    repeat (2) @(negedge clk);
    chk("R2", "scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule